// File: doc/BRIEF.md
# Dual-Chain Replica Delay Monitor Sequencer

This block is the local controller of an on-chip performance monitor made of two replica gate chains. One chain is built from NOR stages and the other from NAND stages. Each chain is tapped at several points by sticky sensor latches. A tap's sensor sets its flag when a transition reaches it inside a guard window just before the next rising clock edge. The flag then stays set until the sensors are reset.

Between measurements the sequencer parks the two chains in opposite bias states. The NOR chain's enable is held high and the NAND chain's enable is held low, so that each chain ages faster than the logic it stands in for. When a start request arrives, the sequencer opens both chains. It launches a rising data edge and then a falling data edge, each on a clock edge, and samples the tap flags after each launch. It then publishes the per-tap OR of both samples as one snapshot with a one-cycle done pulse. Finally it pulses the sensor reset and parks the chains again.

Power-management logic reads the snapshot as a count of late taps and uses it to move voltage or frequency.

Top module: `bias_chain_probe`

## Requirements
- R1: While `busy_o` is low, including during and after reset, `nor_en_o` is 1 and `nand_en_o` is 0, and both data outputs are 0.
- R2: A start sampled high in idle raises `busy_o` after that edge (edge E0). Both chains are enabled (`nor_en_o`=0, `nand_en_o`=1) from E0 until edge E5.
- R3: Both data outputs go from 0 to 1 on edge E1 and stay at 1 for two cycles. This is the rising launch.
- R4: Both data outputs go from 1 to 0 on edge E3 and stay at 0. This is the falling launch.
- R5: The snapshot is the OR of the flags sampled at E3 and at E5. NOR tap k is on `result_o` bit k, and NAND tap k is on bit TAPS+k.
- R6: `done_o` is high for exactly the one cycle between E6 and E7. `result_o` takes the new snapshot at E6 and does not change at any other time.
- R7: `sens_rst_no` is low for exactly the cycle that `done_o` is high, and whenever `rst_ni` is low. A following measurement therefore starts from cleared flags.
- R8: `busy_o` stays high from E0 until E7 and is low afterwards.
- R9: A start request while `busy_o` is high is ignored. It adds no done pulse and does not extend `busy_o`.
- R10: A busy rising edge only follows a cycle in which start was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Measurement request |
| nor_flag_i | input | TAPS | Sticky flags of the NOR-chain taps |
| nand_flag_i | input | TAPS | Sticky flags of the NAND-chain taps |
| nor_data_o | output | 1 | Stimulus into the NOR chain |
| nor_en_o | output | 1 | NOR chain force, high while parked |
| nand_data_o | output | 1 | Stimulus into the NAND chain |
| nand_en_o | output | 1 | NAND chain enable, low while parked |
| sens_rst_no | output | 1 | Active-low sensor clear |
| busy_o | output | 1 | Measurement in progress |
| done_o | output | 1 | One-cycle snapshot strobe |
| result_o | output | 2*TAPS | Snapshot, NOR taps low, NAND taps high |

## Verification
The bench gives each tap separate late masks for rise and fall, so a tap can be late on only one polarity. A design that reported just one capture would then lose bits. A run with all masks clear follows a run with flags set. This catches a sensor reset that is missing or misplaced, because the stale flags would reappear in the snapshot. A start pulse in the middle of a measurement exposes a sequencer that restarts or stretches `busy_o`, since the done pulse would come late or twice. Checks on every cycle of the park-and-launch schedule catch inverted enable polarity and launches that come one cycle early or late.

// File: rtl/bcp_pkg.sv
package bcp_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ENABLE,
      ST_RISE,
      ST_HOLD_R,
      ST_FALL,
      ST_HOLD_F,
      ST_SNAP,
      ST_CLEAR
   } seq_st_t;
endpackage

// File: rtl/bcp_fsm.sv
module bcp_fsm
   import bcp_pkg::*;
#(
   parameter int ENABLE_CYCLES = 1
) (
   input  logic    clk_i,
   input  logic    rst_ni,
   input  logic    start_i,
   output seq_st_t state_o,
   output logic    done_o
);
   localparam int CW = (ENABLE_CYCLES > 1) ? $clog2(ENABLE_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(ENABLE_CYCLES - 1);

   seq_st_t st_q, st_d;
   logic [CW-1:0] cnt_q;
   logic done_q;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:   if (start_i) st_d = ST_ENABLE;
         ST_ENABLE: if (cnt_q == LAST) st_d = ST_RISE;
         ST_RISE:   st_d = ST_HOLD_R;
         ST_HOLD_R: st_d = ST_FALL;
         ST_FALL:   st_d = ST_HOLD_F;
         ST_HOLD_F: st_d = ST_SNAP;
         ST_SNAP:   st_d = ST_CLEAR;
         ST_CLEAR:  st_d = ST_IDLE;
         default:   st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= (st_q == ST_SNAP);
         if (st_q == ST_ENABLE && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
         else                                    cnt_q <= '0;
      end
   end

   assign state_o = st_q;
   assign done_o  = done_q;
endmodule

// File: rtl/bcp_drive.sv
module bcp_drive
   import bcp_pkg::*;
(
   input  logic    rst_ni,
   input  seq_st_t state_i,
   output logic    nor_data_o,
   output logic    nor_en_o,
   output logic    nand_data_o,
   output logic    nand_en_o,
   output logic    sens_rst_no,
   output logic    busy_o
);
   logic open_w, high_w;

   always_comb begin
      open_w = 1'b0;
      high_w = 1'b0;
      unique case (state_i)
         ST_ENABLE, ST_FALL, ST_HOLD_F: open_w = 1'b1;
         ST_RISE, ST_HOLD_R: begin
            open_w = 1'b1;
            high_w = 1'b1;
         end
         default: ;
      endcase
   end

   assign nor_en_o    = ~open_w;
   assign nand_en_o   = open_w;
   assign nor_data_o  = high_w;
   assign nand_data_o = high_w;
   assign busy_o      = (state_i != ST_IDLE);
   assign sens_rst_no = rst_ni & (state_i != ST_CLEAR);
endmodule

// File: rtl/bcp_capture.sv
module bcp_capture
   import bcp_pkg::*;
#(
   parameter int TAPS = 7
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  seq_st_t         state_i,
   input  logic [TAPS-1:0] flag_i,
   output logic [TAPS-1:0] snap_o
);
   logic [TAPS-1:0] acc_q, snap_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q  <= '0;
         snap_q <= '0;
      end else begin
         unique case (state_i)
            ST_ENABLE:            acc_q  <= '0;
            ST_HOLD_R, ST_HOLD_F: acc_q  <= acc_q | flag_i;
            ST_SNAP:              snap_q <= acc_q;
            default: ;
         endcase
      end
   end

   assign snap_o = snap_q;
endmodule

// File: rtl/bias_chain_probe.sv
module bias_chain_probe
   import bcp_pkg::*;
#(
   parameter int TAPS          = 7,
   parameter int ENABLE_CYCLES = 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [TAPS-1:0]   nor_flag_i,
   input  logic [TAPS-1:0]   nand_flag_i,
   output logic              nor_data_o,
   output logic              nor_en_o,
   output logic              nand_data_o,
   output logic              nand_en_o,
   output logic              sens_rst_no,
   output logic              busy_o,
   output logic              done_o,
   output logic [2*TAPS-1:0] result_o
);
   localparam int CHAINS = 2;
   localparam int RW     = CHAINS * TAPS;

   if (TAPS < 1) begin : g_bad_taps
      $error("TAPS must be at least 1");
   end
   if (ENABLE_CYCLES < 1) begin : g_bad_en
      $error("ENABLE_CYCLES must be at least 1");
   end

   seq_st_t state_w;
   logic [RW-1:0] flags_w;

   assign flags_w = {nand_flag_i, nor_flag_i};

   bcp_fsm #(.ENABLE_CYCLES(ENABLE_CYCLES)) i_fsm (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start_i),
      .state_o (state_w),
      .done_o  (done_o)
   );

   bcp_drive i_drive (
      .rst_ni      (rst_ni),
      .state_i     (state_w),
      .nor_data_o  (nor_data_o),
      .nor_en_o    (nor_en_o),
      .nand_data_o (nand_data_o),
      .nand_en_o   (nand_en_o),
      .sens_rst_no (sens_rst_no),
      .busy_o      (busy_o)
   );

   for (genvar c = 0; c < CHAINS; c++) begin : g_chain
      bcp_capture #(.TAPS(TAPS)) i_cap (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .state_i (state_w),
         .flag_i  (flags_w[c*TAPS +: TAPS]),
         .snap_o  (result_o[c*TAPS +: TAPS])
      );
   end
endmodule

// File: rtl/bcp_checker.sv
module bcp_checker #(
   parameter int TAPS = 7
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              start_i,
   input logic              nor_data_o,
   input logic              nor_en_o,
   input logic              nand_data_o,
   input logic              nand_en_o,
   input logic              sens_rst_no,
   input logic              busy_o,
   input logic              done_o,
   input logic [2*TAPS-1:0] result_o
);
   assert_idle_bias_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> (nor_en_o && !nand_en_o && !nor_data_o && !nand_data_o));

   assert_launch_enabled_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(nor_data_o) |-> (!nor_en_o && nand_en_o));

   assert_done_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   assert_result_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_o |-> $stable(result_o));

   assert_clear_with_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !sens_rst_no);

   assert_busy_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_o) |-> $past(start_i));
endmodule

bind bias_chain_probe bcp_checker #(.TAPS(TAPS)) i_bcp_checker (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .start_i     (start_i),
   .nor_data_o  (nor_data_o),
   .nor_en_o    (nor_en_o),
   .nand_data_o (nand_data_o),
   .nand_en_o   (nand_en_o),
   .sens_rst_no (sens_rst_no),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .result_o    (result_o)
);

// File: tb/test_bias_chain_probe.sv
`timescale 1ns/1ps
module test_bias_chain_probe;
   localparam int TAPS = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [TAPS-1:0] nor_fl = '0, nand_fl = '0;
   logic nor_d, nor_e, nand_d, nand_e, srst_n, busy, done;
   logic [2*TAPS-1:0] result;

   logic [TAPS-1:0] nor_rl = '0, nor_fll = '0, nand_rl = '0, nand_fll = '0;
   logic last_nor = 1'b0, last_nand = 1'b0;

   int n_cmp = 0, n_bad = 0, n_done = 0;
   logic [2*TAPS-1:0] exp_q[$];

   always #2.5 clk = ~clk;

   bias_chain_probe #(.TAPS(TAPS)) i_bias_chain_probe (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start),
      .nor_flag_i(nor_fl), .nand_flag_i(nand_fl),
      .nor_data_o(nor_d), .nor_en_o(nor_e),
      .nand_data_o(nand_d), .nand_en_o(nand_e),
      .sens_rst_no(srst_n), .busy_o(busy), .done_o(done), .result_o(result));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // behavioural sticky sensors on the two chains
   always @(negedge clk) begin
      if (!srst_n) begin
         nor_fl  = '0;
         nand_fl = '0;
      end else begin
         if (!nor_e && nor_d && !last_nor)   nor_fl = nor_fl | nor_rl;
         if (!nor_e && !nor_d && last_nor)   nor_fl = nor_fl | nor_fll;
         if (nand_e && nand_d && !last_nand) nand_fl = nand_fl | nand_rl;
         if (nand_e && !nand_d && last_nand) nand_fl = nand_fl | nand_fll;
      end
      last_nor  = nor_d;
      last_nand = nand_d;
   end

   // monitor: scoreboard pop on done
   always @(negedge clk) begin
      if (rst_n && done) begin
         n_done++;
         if (exp_q.size() == 0) chk("R9 unexpected done", 32'd1, 32'd0);
         else chk("R5 snapshot", 32'(result), 32'(exp_q.pop_front()));
      end
   end

   task automatic measure(input logic [TAPS-1:0] a, b, c, d, input bit poke);
      nor_rl = a; nor_fll = b; nand_rl = c; nand_fll = d;
      exp_q.push_back({c | d, a | b});
      @(negedge clk) start = 1'b1;
      for (int k = 1; k <= 8; k++) begin
         @(negedge clk);
         start = (poke && (k == 3 || k == 4)) ? 1'b1 : 1'b0;
         if (k <= 5) begin
            chk("R2 nor enable open", 32'(nor_e), 32'd0);
            chk("R2 nand enable open", 32'(nand_e), 32'd1);
         end
         if (k == 2 || k == 3) chk("R3 rise data", 32'({nor_d, nand_d}), 32'd3);
         if (k == 1 || k == 4 || k == 5) chk("R4 low data", 32'({nor_d, nand_d}), 32'd0);
         if (k <= 7) chk("R8 busy held", 32'(busy), 32'd1);
         chk("R6 done timing", 32'(done), (k == 7) ? 32'd1 : 32'd0);
         chk("R7 sensor clear", 32'(srst_n), (k == 7) ? 32'd0 : 32'd1);
         if (k >= 6) chk("R1 parked bias", 32'({nor_e, nand_e, nor_d, nand_d}), 32'b1000);
         if (k == 8) chk("R8 busy drop", 32'(busy), 32'd0);
      end
   endtask

   initial begin
      #1000000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R7 clear in reset", 32'(srst_n), 32'd0);
      chk("R1 reset bias", 32'({nor_e, nand_e, nor_d, nand_d}), 32'b1000);
      chk("R8 reset busy", 32'(busy), 32'd0);
      chk("R6 reset done/result", 32'({done, result}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R7 released", 32'(srst_n), 32'd1);
      chk("R1 idle bias", 32'({nor_e, nand_e}), 32'b10);

      measure(7'b0000011, 7'b0000000, 7'b0000000, 7'b0000000, 1'b0);
      measure(7'b0001000, 7'b0110000, 7'b0000101, 7'b1000000, 1'b0);
      measure(7'b0000000, 7'b0000000, 7'b0000000, 7'b0000000, 1'b0);
      measure(7'b1111111, 7'b1111111, 7'b1111111, 7'b0000000, 1'b1);
      repeat (10) begin
         @(negedge clk);
         chk("R9 no restart", 32'(busy), 32'd0);
      end
      measure(7'b0000000, 7'b1010101, 7'b0101010, 7'b0000001, 1'b0);
      repeat (3) @(negedge clk);
      chk("R9 done count", 32'(n_done), 32'd5);
      chk("R5 queue drained", 32'(exp_q.size()), 32'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule